// File: doc/BRIEF.md
# External Interrupt Flag Register with Guarded Software Clear

This block keeps one sticky status flag per external interrupt line in a single bus-visible register. A rising edge on a line's input sets that line's flag, and every set flag drives the matching interrupt request output. Software sees all flags at once on the read port. A line's flag can be cleared in two ways: by software, or by a hardware strobe issued when exception handling for that line begins. Different lines may use different methods at the same time.

Software clearing is guarded. A byte write of 0 clears a bit only if the last read of the register, taken since the previous write, returned 1 for that bit. A read-modify-write aimed at one line can carry a stale 0 for a flag that became set after the read. That stale 0 then cannot wipe out an event that nobody has serviced. Each bit has an armed latch: a read that returns 1 arms the bit, and any write disarms every bit.

Top module: `irq_flag_reg`

## Requirements
- R1: After synchronous reset, every flag is 0, every armed latch is clear, and `irq_req_o` is all zeros.
- R2: A 0-to-1 transition on `irq_pin_i[i]` sets flag i at the next clock edge. Holding the input high does not set the flag again once it has been cleared.
- R3: `rd_data_o` and `irq_req_o` both show the current flag vector, with bit i belonging to line i.
- R4: A write (`wr_en_i`=1) whose `wr_data_i[i]` is 0 clears flag i if the most recent read since the last write returned 1 in bit i.
- R5: A write of 0 to bit i leaves flag i set if bit i was not read as 1 since the previous write. This covers the cases where no read happened and where the read returned 0 because the flag set later.
- R6: Writing 1 to any bit never changes that flag. Flags are set only by their input edges.
- R7: Every write disarms all bits, whatever data it carries. A second write of 0 after a write of 1 does not clear the flag without a new read.
- R8: `hw_clr_i[i]` clears flag i at the next edge with no read needed, and it also disarms bit i. A later write of 0 then does not clear a newly set flag i.
- R9: If a rising edge and a clear (software or hardware) reach the same bit in the same cycle, the flag ends set.
- R10: A byte read-modify-write that clears one bit does not disturb other bits. A bit that set after the read keeps its flag even though the write carries 0 for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pin_i | input | NUM_LINES | External interrupt inputs, rising edge sets the flag |
| rd_en_i | input | 1 | Register read strobe, arms bits that read as 1 |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | NUM_LINES | Write data, 0 requests clear of an armed bit |
| hw_clr_i | input | NUM_LINES | Per-line clear strobe on exception acceptance |
| rd_data_o | output | NUM_LINES | Current flag vector for the read port |
| irq_req_o | output | NUM_LINES | Interrupt request per line |

## Verification
Clear attempts are tried under several read histories: no read at all, a read that returned 0, a read that returned 1, a read followed by an intervening write, and a read followed by a hardware clear. Only the read-that-returned-1 case may clear a flag. A held-high input shows that edge detection, and not the input level, sets a flag. Same-cycle collisions of an edge with both kinds of clear show that the set wins. A stale-zero byte write across two lines shows that the arming is tracked per bit and not for the whole register.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;

    localparam int DEFAULT_LINES = 8;

    // Per-bit command gathered from the bus and the clear strobes
    typedef struct packed {
        logic set_evt;   // edge seen on the line
        logic bus_rd;    // register read this cycle
        logic bus_wr;    // register write this cycle
        logic wr_bit;    // write data for this bit
        logic hw_clr;    // exception-acceptance clear
    } bit_cmd_t;

    typedef struct packed {
        logic flag;
        logic armed;
    } bit_state_t;

    function automatic bit_state_t next_bit_state(bit_state_t cur, bit_cmd_t cmd);
        bit_state_t nxt;
        logic sw_clear;
        sw_clear = cmd.bus_wr && !cmd.wr_bit && cur.armed;
        if (cmd.set_evt)
            nxt.flag = 1'b1;
        else if (sw_clear || cmd.hw_clr)
            nxt.flag = 1'b0;
        else
            nxt.flag = cur.flag;
        if (cmd.hw_clr)
            nxt.armed = 1'b0;
        else
            nxt.armed = (cmd.bus_wr ? 1'b0 : cur.armed) | (cmd.bus_rd & cur.flag);
        return nxt;
    endfunction

endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] level_i,
    output logic [WIDTH-1:0] rise_o
);
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= level_i;
    end

    assign rise_o = level_i & ~prev_q;
endmodule

// File: rtl/irq_flag_cell.sv
module irq_flag_cell
    import irq_flag_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  bit_cmd_t cmd_i,
    output logic     flag_o,
    output logic     armed_o
);
    bit_state_t st_q;

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= next_bit_state(st_q, cmd_i);
    end

    assign flag_o  = st_q.flag;
    assign armed_o = st_q.armed;
endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg
    import irq_flag_pkg::*;
#(
    parameter int NUM_LINES = DEFAULT_LINES
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] irq_pin_i,
    input  logic                 rd_en_i,
    input  logic                 wr_en_i,
    input  logic [NUM_LINES-1:0] wr_data_i,
    input  logic [NUM_LINES-1:0] hw_clr_i,
    output logic [NUM_LINES-1:0] rd_data_o,
    output logic [NUM_LINES-1:0] irq_req_o
);
    logic [NUM_LINES-1:0] rise_w;
    logic [NUM_LINES-1:0] flag_w;
    logic [NUM_LINES-1:0] armed_w;

    irq_edge_detect #(.WIDTH(NUM_LINES)) u_edge (
        .clk     (clk),
        .rst     (rst),
        .level_i (irq_pin_i),
        .rise_o  (rise_w)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_bit
        bit_cmd_t cmd;
        always_comb begin
            cmd.set_evt = rise_w[i];
            cmd.bus_rd  = rd_en_i;
            cmd.bus_wr  = wr_en_i;
            cmd.wr_bit  = wr_data_i[i];
            cmd.hw_clr  = hw_clr_i[i];
        end
        irq_flag_cell u_cell (
            .clk     (clk),
            .rst     (rst),
            .cmd_i   (cmd),
            .flag_o  (flag_w[i]),
            .armed_o (armed_w[i])
        );
    end

    assign rd_data_o = flag_w;
    assign irq_req_o = flag_w;
endmodule

// File: rtl/irq_flag_reg_chk.sv
module irq_flag_reg_chk #(
    parameter int NUM_LINES = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 wr_en_i,
    input logic [NUM_LINES-1:0] hw_clr_i,
    input logic [NUM_LINES-1:0] rise_w,
    input logic [NUM_LINES-1:0] armed_w,
    input logic [NUM_LINES-1:0] rd_data_o
);
    // R2 / R9: an edge always leaves its flag set, whatever clears collide
    assert_edge_sets_R2: assert property (@(posedge clk) disable iff (rst)
        (rise_w != '0) |=> ((rd_data_o & $past(rise_w)) == $past(rise_w)));

    // R6: no flag turns on without an edge
    assert_no_spurious_set_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((rd_data_o & ~$past(rd_data_o) & ~$past(rise_w)) == '0));

    // R5: a write cannot clear a bit that was not armed
    assert_unarmed_kept_R5: assert property (@(posedge clk) disable iff (rst)
        wr_en_i |=> (($past(rd_data_o) & ~$past(armed_w) & ~$past(hw_clr_i) & ~rd_data_o) == '0));

    // R8: hardware clear without a colliding edge empties the flag
    assert_hw_clear_R8: assert property (@(posedge clk) disable iff (rst)
        ((hw_clr_i & ~rise_w) != '0) |=> ((rd_data_o & $past(hw_clr_i & ~rise_w)) == '0));

    // R7: every write leaves only bits that were armed by nothing (all clear)
    assert_write_disarms_R7: assert property (@(posedge clk) disable iff (rst)
        wr_en_i |=> ((armed_w & ~$past(rd_data_o)) == '0));
endmodule

bind irq_flag_reg irq_flag_reg_chk #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en_i   (wr_en_i),
    .hw_clr_i  (hw_clr_i),
    .rise_w    (rise_w),
    .armed_w   (armed_w),
    .rd_data_o (rd_data_o)
);

// File: tb/tb_irq_flag_reg.sv
`timescale 1ns/1ps
module tb_irq_flag_reg;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] irq_pin_i = '0;
    logic         rd_en_i = 1'b0;
    logic         wr_en_i = 1'b0;
    logic [N-1:0] wr_data_i = '0;
    logic [N-1:0] hw_clr_i = '0;
    logic [N-1:0] rd_data_o;
    logic [N-1:0] irq_req_o;

    always #2 clk = ~clk;

    irq_flag_reg #(.NUM_LINES(N)) dut (
        .clk(clk), .rst(rst), .irq_pin_i(irq_pin_i), .rd_en_i(rd_en_i),
        .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .hw_clr_i(hw_clr_i),
        .rd_data_o(rd_data_o), .irq_req_o(irq_req_o)
    );

    typedef struct {
        string        tag;
        bit           use_req;
        logic [N-1:0] exp;
    } item_t;

    item_t queue_q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    event  sample_ev;

    // Monitor: pops expected items and compares with the live outputs
    initial begin
        forever begin
            @(sample_ev);
            while (queue_q.size() > 0) begin
                item_t it;
                logic [N-1:0] act;
                it  = queue_q.pop_front();
                act = it.use_req ? irq_req_o : rd_data_o;
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual=%02h expected=%02h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic expect_val(string tag, bit use_req, logic [N-1:0] exp);
        item_t it;
        it.tag = tag; it.use_req = use_req; it.exp = exp;
        queue_q.push_back(it);
        ->sample_ev;
        #0.1;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_read(output logic [N-1:0] v);
        v = rd_data_o;
        rd_en_i = 1'b1; tick(); rd_en_i = 1'b0;
    endtask

    task automatic do_write(logic [N-1:0] d);
        wr_en_i = 1'b1; wr_data_i = d; tick(); wr_en_i = 1'b0; wr_data_i = '0;
    endtask

    task automatic pulse(logic [N-1:0] m);
        irq_pin_i = irq_pin_i | m; tick(); irq_pin_i = irq_pin_i & ~m; tick();
    endtask

    task automatic hwclr(logic [N-1:0] m);
        hw_clr_i = m; tick(); hw_clr_i = '0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] rv;
        tick(); tick(); rst = 1'b0; tick();
        expect_val("R1 flags after reset", 0, 8'h00);
        expect_val("R1 requests after reset", 1, 8'h00);

        pulse(8'h01);
        expect_val("R2 edge sets bit0", 0, 8'h01);
        expect_val("R3 request follows flag", 1, 8'h01);

        do_write(8'h00);
        expect_val("R5 write0 without read keeps", 0, 8'h01);

        do_read(rv);
        expect_val("R3 read value", 0, rv);
        do_write(8'h00);
        expect_val("R4 read1 then write0 clears", 0, 8'h00);

        irq_pin_i[3] = 1'b1; tick(); tick();
        expect_val("R2 held high sets once", 0, 8'h08);
        do_read(rv); do_write(8'h00);
        tick(); tick(); tick();
        expect_val("R2 held level does not reset flag", 0, 8'h00);
        irq_pin_i[3] = 1'b0; tick();

        pulse(8'h80);
        do_read(rv); do_write(8'hFF);
        expect_val("R6 write1 no effect", 0, 8'h80);
        do_write(8'h00);
        expect_val("R7 write consumed arm", 0, 8'h80);
        hwclr(8'h80);

        do_read(rv);
        pulse(8'h02);
        do_write(8'h00);
        expect_val("R5 read-as-0 then write0 keeps", 0, 8'h02);
        do_read(rv); do_write(8'hFD);
        expect_val("R4 clear bit1", 0, 8'h00);

        pulse(8'h04);
        do_read(rv);
        hwclr(8'h04);
        expect_val("R8 hw clear", 0, 8'h00);
        pulse(8'h04);
        do_write(8'h00);
        expect_val("R8 hw clear disarmed", 0, 8'h04);
        hwclr(8'h04);

        pulse(8'h10);
        do_read(rv);
        irq_pin_i[4] = 1'b1; wr_en_i = 1'b1; wr_data_i = 8'h00; tick();
        wr_en_i = 1'b0;
        expect_val("R9 set beats sw clear", 0, 8'h10);
        irq_pin_i[4] = 1'b0; tick();
        irq_pin_i[4] = 1'b1; hw_clr_i = 8'h10; tick(); hw_clr_i = '0;
        expect_val("R9 set beats hw clear", 0, 8'h10);
        irq_pin_i[4] = 1'b0; hwclr(8'h10);
        expect_val("R8 cleanup", 0, 8'h00);

        pulse(8'h20);
        do_read(rv);
        pulse(8'h40);
        do_write(rv & ~8'h20);
        expect_val("R10 stale zero keeps other bit", 0, 8'h40);
        expect_val("R10 request line kept", 1, 8'h40);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule